// File: doc/BRIEF.md
# Low-Power Wakeup Event Controller

This block collects wakeup events for a chip in a low-power state. Two 31-pin GPIO ports are synchronized and watched for level changes in either direction. Six low-power peripheral sources deliver single-cycle event pulses: two low-power timers, a low-power UART, two comparators and a backup-mode return. Each event lands in a sticky status flag that stays set until software clears it by writing a one.

A single level-sensitive interrupt output wakes the processor. A GPIO flag contributes only when its per-pin enable is set and the global GPIO wake input is high. A peripheral flag contributes when its own enable bit is set.

A simple register bus reads and writes the status and enable registers. Reads are combinational from the address. Writes take effect on the clock edge on which the select and write strobes are sampled high. The peripheral status register also shows the live output levels of the two comparators.

Top module: `lpwk_event_ctrl`

## Requirements
- R1: A GPIO status bit sets on a rising or a falling level change of its pin. The bit is readable as set after the third rising clock edge that follows the change, and is still clear after the second.
- R2: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R3: If an event and a clearing write hit the same flag on the same clock edge, the flag ends up set.
- R4: A status flag latches whether or not its enable bit is set. It stays set after the pin returns to its earlier level.
- R5: GPIO flags drive `wake_irq_o` only when three things hold: the flag is set, its per-pin enable bit is set, and `gpio_wake_en_i` is high.
- R6: Peripheral event pulses latch into status bits as follows:
  - timer 0 into bit 0
  - timer 1 into bit 1
  - UART into bit 2
  - comparator 0 into bit 3
  - comparator 1 into bit 4
  - backup into bit 16

  Peripheral enable bits 0 to 4 gate status bits 0 to 4 onto `wake_irq_o`. Bit 16 never drives the interrupt.
- R7: Status bits 5 and 6 of the peripheral register read the live levels of comparator 0 and comparator 1. Writes to these bits are ignored.
- R8: The following read as zero and ignore writes:
  - bit 31 of every GPIO register
  - peripheral status bits 15:7 and 31:17
  - peripheral enable bits 31:5
  - any unmapped address
- R9: After reset, all status and enable registers read zero and `wake_irq_o` is low. A pin held high through reset does not produce an event.
- R10: Register offsets are:
  - port 0 status at 0x04, port 0 enable at 0x08
  - port 1 status at 0x0C, port 1 enable at 0x10
  - peripheral status at 0x30, peripheral enable at 0x34

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_wake_en_i | input | 1 | Global enable for GPIO wakeup |
| port0_pins_i | input | 31 | Asynchronous pin levels of GPIO port 0 |
| port1_pins_i | input | 31 | Asynchronous pin levels of GPIO port 1 |
| per_evt_i | input | 6 | Peripheral event pulses: [0] timer 0, [1] timer 1, [2] UART, [3] comparator 0, [4] comparator 1, [5] backup |
| cmp_level_i | input | 2 | Live comparator output levels |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| wake_irq_o | output | 1 | Level wakeup interrupt |

## Verification
The embedded assertions check the following on every cycle:
- an event always leaves its flag set, even when a clearing write arrives on the same edge;
- a flag with neither event nor clear holds its value;
- a clear with no event empties the cleared bits;
- the interrupt never rises without a qualifying source;
- reserved peripheral bits read zero;
- the comparator bits mirror their inputs.

Some behaviour only the directed scenarios can show:
- the exact three-edge latency from a pin change;
- detection of both edges;
- the absence of a spurious event for a pin held high through reset;
- the full three-way GPIO interrupt qualification;
- the exclusion of the backup flag from the interrupt;
- the mapping of every offset.

// File: rtl/lpwk_pkg.sv
package lpwk_pkg;
  localparam int LPWK_AW     = 8;
  localparam int LPWK_DW     = 32;
  localparam int GPIO_W      = 31;
  localparam int NPORT       = 2;
  localparam int PER_N       = 6;   // five gated sources + backup
  localparam int PER_GATED   = 5;
  localparam int SYNC_STAGES = 2;

  localparam logic [LPWK_AW-1:0] OFS_PORT_ST  = 8'h04; // + 8 per port
  localparam logic [LPWK_AW-1:0] OFS_PORT_EN  = 8'h08; // + 8 per port
  localparam logic [LPWK_AW-1:0] OFS_PORT_STEP = 8'h08;
  localparam logic [LPWK_AW-1:0] OFS_PER_ST   = 8'h30;
  localparam logic [LPWK_AW-1:0] OFS_PER_EN   = 8'h34;

  localparam int BIT_BACKUP = 16;
  localparam int BIT_CMP_LV = 5;
endpackage

// File: rtl/lpwk_edge_det.sv
module lpwk_edge_det #(
  parameter int W      = 31,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0]    sync_q [STAGES];
  logic [W-1:0]    prev_q;
  logic [STAGES:0] arm_q;   // edges qualified only once the pipe holds real samples

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      sync_q[0] <= pins_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
      arm_q  <= {arm_q[STAGES-1:0], 1'b1};
    end
  end

  assign edge_o = arm_q[STAGES] ? (sync_q[STAGES-1] ^ prev_q) : '0;
endmodule

// File: rtl/lpwk_flag_bank.sv
module lpwk_flag_bank #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;  // event wins
  end

  assign flags_o = flags_q;

  a_r3_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  a_r2_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i != '0) |=> ((flags_o & $past(clr_i)) == '0));

  a_r4_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/lpwk_event_ctrl.sv
module lpwk_event_ctrl
  import lpwk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gpio_wake_en_i,
  input  logic [GPIO_W-1:0]  port0_pins_i,
  input  logic [GPIO_W-1:0]  port1_pins_i,
  input  logic [PER_N-1:0]   per_evt_i,
  input  logic [1:0]         cmp_level_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [LPWK_AW-1:0] bus_addr_i,
  input  logic [LPWK_DW-1:0] bus_wdata_i,
  output logic [LPWK_DW-1:0] bus_rdata_o,
  output logic               wake_irq_o
);
  logic               wr;
  logic [GPIO_W-1:0]  pins   [NPORT];
  logic [GPIO_W-1:0]  st     [NPORT];
  logic [GPIO_W-1:0]  en_q   [NPORT];
  logic [NPORT-1:0]   port_hit;
  logic [PER_N-1:0]   per_st;
  logic [PER_N-1:0]   per_clr;
  logic [PER_GATED-1:0] per_en_q;
  logic               unused_wdata;

  assign wr           = bus_sel_i & bus_we_i;
  assign pins[0]      = port0_pins_i;
  assign pins[1]      = port1_pins_i;
  assign unused_wdata = bus_wdata_i[LPWK_DW-1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [LPWK_AW-1:0] ST_ADDR = OFS_PORT_ST + LPWK_AW'(p) * OFS_PORT_STEP;
    localparam logic [LPWK_AW-1:0] EN_ADDR = OFS_PORT_EN + LPWK_AW'(p) * OFS_PORT_STEP;
    logic [GPIO_W-1:0] edges;
    logic [GPIO_W-1:0] clr;

    lpwk_edge_det #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i), .rst_ni(rst_ni), .pins_i(pins[p]), .edge_o(edges)
    );

    assign clr = (wr && bus_addr_i == ST_ADDR) ? bus_wdata_i[GPIO_W-1:0] : '0;

    lpwk_flag_bank #(.W(GPIO_W)) u_flags (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(edges), .clr_i(clr), .flags_o(st[p])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         en_q[p] <= '0;
      else if (wr && bus_addr_i == EN_ADDR) en_q[p] <= bus_wdata_i[GPIO_W-1:0];
    end

    assign port_hit[p] = |(st[p] & en_q[p]);
  end

  // peripheral flags: [4:0] gated sources, [5] backup (reported at bit 16)
  always_comb begin
    per_clr = '0;
    if (wr && bus_addr_i == OFS_PER_ST)
      per_clr = {bus_wdata_i[BIT_BACKUP], bus_wdata_i[PER_GATED-1:0]};
  end

  lpwk_flag_bank #(.W(PER_N)) u_per_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(per_evt_i), .clr_i(per_clr), .flags_o(per_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            per_en_q <= '0;
    else if (wr && bus_addr_i == OFS_PER_EN) per_en_q <= bus_wdata_i[PER_GATED-1:0];
  end

  assign wake_irq_o = (gpio_wake_en_i & (|port_hit)) | (|(per_st[PER_GATED-1:0] & per_en_q));

  always_comb begin
    bus_rdata_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr_i == OFS_PORT_ST + LPWK_AW'(p) * OFS_PORT_STEP) bus_rdata_o = {1'b0, st[p]};
      if (bus_addr_i == OFS_PORT_EN + LPWK_AW'(p) * OFS_PORT_STEP) bus_rdata_o = {1'b0, en_q[p]};
    end
    if (bus_addr_i == OFS_PER_ST) begin
      bus_rdata_o[PER_GATED-1:0]           = per_st[PER_GATED-1:0];
      bus_rdata_o[BIT_CMP_LV+1:BIT_CMP_LV] = cmp_level_i;
      bus_rdata_o[BIT_BACKUP]              = per_st[PER_N-1];
    end
    if (bus_addr_i == OFS_PER_EN) bus_rdata_o[PER_GATED-1:0] = per_en_q;
  end

  a_r5_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> (gpio_wake_en_i || (per_st[PER_GATED-1:0] != '0)));

  a_r6_backup_not_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gpio_wake_en_i && per_st[PER_GATED-1:0] == '0) |-> !wake_irq_o);

  a_r7_cmp_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_PER_ST) |-> (bus_rdata_o[6:5] == cmp_level_i));

  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_PER_ST) |-> (bus_rdata_o[31:17] == '0 && bus_rdata_o[15:7] == '0));
endmodule

// File: tb/lpwk_event_ctrl_tb.sv
module lpwk_event_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gwake = 1'b0;
  logic [30:0] p0 = '0, p1 = '0;
  logic [5:0]  pevt = '0;
  logic [1:0]  cmp = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          vectors = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  lpwk_event_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gpio_wake_en_i(gwake),
    .port0_pins_i(p0), .port1_pins_i(p1), .per_evt_i(pevt), .cmp_level_i(cmp),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .wake_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(1);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [5:0] m);
    pevt = m; tick(1); pevt = '0;
  endtask

  task automatic t_reset;
    p0 = 31'h5555_5555; p1 = 31'h7fff_ffff;
    tick(3); rst_n = 1'b1; tick(6);
    rd_chk("R9 port0 status", 8'h04, 0);
    rd_chk("R9 port1 status", 8'h0C, 0);
    rd_chk("R9 port0 enable", 8'h08, 0);
    rd_chk("R9 port1 enable", 8'h10, 0);
    rd_chk("R9 per status",   8'h30, 0);
    rd_chk("R9 per enable",   8'h34, 0);
    check("R9 irq", {31'b0, irq}, 0);
    p0 = '0; p1 = '0; tick(4);
    wr(8'h04, 32'hffff_ffff); wr(8'h0C, 32'hffff_ffff);
    rd_chk("R2 clear after reset", 8'h04, 0);
  endtask

  task automatic t_edges;
    p1[3] = 1'b1; tick(2);
    rd_chk("R1 rise latency 2", 8'h0C, 0);
    tick(1);
    rd_chk("R1 rise latency 3", 8'h0C, 32'h8);
    wr(8'h0C, 32'h8);
    p1[3] = 1'b0; tick(3);
    rd_chk("R1 fall", 8'h0C, 32'h8);
    wr(8'h0C, 32'h8);
    p0[30] = 1'b1; tick(3);
    rd_chk("R10 port0 bit30", 8'h04, 32'h4000_0000);
    rd_chk("R10 port1 untouched", 8'h0C, 0);
    wr(8'h04, 32'hffff_ffff);
    p0[30] = 1'b0; tick(3); wr(8'h04, 32'hffff_ffff);
  endtask

  task automatic t_w1c;
    p0[1:0] = 2'b11; tick(3);
    wr(8'h04, 32'h0);
    rd_chk("R2 zero write", 8'h04, 32'h3);
    wr(8'h04, 32'h1);
    rd_chk("R2 one bit", 8'h04, 32'h2);
    wr(8'h04, 32'hffff_ffff);
    rd_chk("R2 all", 8'h04, 0);
    p0[1:0] = 2'b00; tick(3); wr(8'h04, 32'h3);
  endtask

  task automatic t_sticky;
    gwake = 1'b1;
    p0[7] = 1'b1; tick(1); p0[7] = 1'b0; tick(5);
    rd_chk("R4 sticky disabled", 8'h04, 32'h80);
    check("R4 no irq when disabled", {31'b0, irq}, 0);
    wr(8'h04, 32'h80); gwake = 1'b0;
  endtask

  task automatic t_irq;
    wr(8'h08, 32'h20);
    rd_chk("R10 port0 enable", 8'h08, 32'h20);
    p0[5] = 1'b1; tick(3);
    check("R5 global off", {31'b0, irq}, 0);
    gwake = 1'b1; #1;
    check("R5 all set", {31'b0, irq}, 1);
    wr(8'h08, 32'h0);
    check("R5 pin enable off", {31'b0, irq}, 0);
    wr(8'h08, 32'h20); wr(8'h04, 32'h20);
    check("R5 flag cleared", {31'b0, irq}, 0);
    wr(8'h08, 32'hffff_ffff);
    rd_chk("R8 gpio bit31", 8'h08, 32'h7fff_ffff);
    wr(8'h08, 0); gwake = 1'b0;
    p0[5] = 1'b0; tick(3); wr(8'h04, 32'h20);
  endtask

  task automatic t_periph;
    for (int i = 0; i < 6; i++) pulse(6'(1 << i));
    rd_chk("R6 all flags", 8'h30, 32'h0001_001f);
    check("R6 irq no enable", {31'b0, irq}, 0);
    wr(8'h34, 32'h10);
    check("R6 cmp1 enabled irq", {31'b0, irq}, 1);
    wr(8'h34, 32'hffff_ffff);
    rd_chk("R8 per enable bits", 8'h34, 32'h1f);
    wr(8'h30, 32'h1f);
    rd_chk("R6 backup remains", 8'h30, 32'h0001_0000);
    check("R6 backup no irq", {31'b0, irq}, 0);
    wr(8'h30, 32'h0001_0000);
    rd_chk("R6 backup cleared", 8'h30, 0);
    wr(8'h34, 0);
  endtask

  task automatic t_cmp;
    cmp = 2'b10; #1;
    rd_chk("R7 cmp1 level", 8'h30, 32'h40);
    wr(8'h30, 32'h60);
    rd_chk("R7 write ignored", 8'h30, 32'h40);
    cmp = 2'b01; #1;
    rd_chk("R7 cmp0 level", 8'h30, 32'h20);
    cmp = 2'b00;
  endtask

  task automatic t_collision;
    pulse(6'h04);
    sel = 1'b1; we = 1'b1; addr = 8'h30; wdata = 32'h4; pevt = 6'h04;
    tick(1);
    sel = 1'b0; we = 1'b0; wdata = '0; pevt = '0;
    rd_chk("R3 event wins", 8'h30, 32'h4);
    wr(8'h30, 32'h4);
    rd_chk("R3 later clear", 8'h30, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h00, 32'hffff_ffff); wr(8'h14, 32'hffff_ffff);
    rd_chk("R8 addr 0x00", 8'h00, 0);
    rd_chk("R8 addr 0x14", 8'h14, 0);
    rd_chk("R8 addr 0x40", 8'h40, 0);
    rd_chk("R8 no side effect", 8'h08, 0);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_w1c();
    t_sticky();
    t_irq();
    t_periph();
    t_cmp();
    t_collision();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule